// File: doc/BRIEF.md
# Slave-Port Bus Arbiter with Legal Switch Points

This block decides which of several bus masters owns a single slave port. Each master raises a request line, and the arbiter keeps a registered one-hot grant. One instance sits in front of each slave, so each slave carries its own configuration. The grant may move to another master only on cycles where a switch cannot break a transfer. These are cycles where the port has no owner or its owner is idle, cycles carrying a single transfer, the final beat of a burst, and the cycle on which a slot timer decides the current owner has held the port long enough.

Two winner-selection schemes can be chosen at run time. The first is a rotating scheme, used when the mode input is low. The second compares a per-master priority value. When nobody requests at a switch point, the grant parks. It parks on a configured default master if that option is on, and on the current owner otherwise. A master that already holds the parked grant can start its transfer at once. Any other master waits one cycle for the registered grant. The end-of-burst input comes from a separate burst-length predictor, so fixed-length and cut-up undefined-length bursts look the same to this block.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While reset is held, and after reset until a switch point selects a master, `gnt` is all zeros and `gnt_vld` is low.
- R2: `gnt` has at most one bit set. When `gnt_vld` is high, `gnt_idx` equals the position of that bit.
- R3: A cycle is a switch point when any of these holds: no master owns the port, `xfer_active` is low, `xfer_single` is high, `burst_last` is high, or the slot limit of R6 is reached. On any other cycle the grant stays unchanged.
- R4: With `cfg_mode` = 0 (rotating), the winner is the first requesting master found by searching upward from the index just above the current or last owner and wrapping past N-1 to 0. After reset the search starts at index 0.
- R5: With `cfg_mode` = 1 (priority), the winner is the requesting master whose field `cfg_prio[m*PRIO_W +: PRIO_W]` is largest. On a tie, the lower index wins.
- R6: A slot counter is cleared on every switch point and counts each following cycle in which the owner is active. When `cfg_slot_limit` is non-zero, the active cycle on which the count equals `cfg_slot_limit`-1 is a switch point. The owner therefore keeps at most `cfg_slot_limit` consecutive busy cycles. A limit of 0 never forces a switch.
- R7: With `cfg_dflt_en` high, a switch point with no request moves the grant to master `cfg_dflt_idx` (below N). That master then sees its grant in the same cycle it first requests. Any other master is granted only in the cycle after the switch point where it requested.
- R8: With `cfg_dflt_en` low, a switch point with no request leaves the grant unchanged, including the no-owner state after reset.
- R9: At a switch point where some master requests, the winner depends only on the mode, the priorities, the requests and the previous owner. The default-master setting has no effect on it.
- R10: A grant decided at a switch point appears on `gnt` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_MST | Request line per master |
| xfer_active | input | 1 | Current owner is driving a transfer this cycle |
| xfer_single | input | 1 | Current transfer is a single beat |
| burst_last | input | 1 | Current beat ends a burst (real or predicted) |
| cfg_mode | input | 1 | 0 rotating, 1 priority |
| cfg_prio | input | N_MST*PRIO_W | Priority field per master |
| cfg_dflt_en | input | 1 | Park on a fixed default master |
| cfg_dflt_idx | input | IDX_W | Index of the default master |
| cfg_slot_limit | input | SLOT_W | Busy-cycle limit per grant, 0 disables |
| gnt | output | N_MST | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted master |
| gnt_vld | output | 1 | A master holds the grant |

## Verification
The hardest case to reach is the slot timer breaking a long burst while other masters are waiting. Every other switch condition has to stay quiet for exactly `cfg_slot_limit` cycles, and random control lines almost never allow that. Directed phases hold `xfer_active` high with the single-beat and last-beat inputs low and every master requesting. They do this for a small limit and again with the limit at zero. The random phase keeps `xfer_active` mostly high and end-of-burst rare, so natural runs of busy cycles also hit the limit. Zero-latency parking is reached by setting a master's request exactly while the grant is parked on it, and by comparing that with a request from a non-default master.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      ARB_ROTATE = 1'b0,
      ARB_PRIO   = 1'b1
   } arb_mode_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          found,
   output logic [IW-1:0] win
);
   always_comb begin
      found = 1'b0;
      win   = last;
      for (int off = 1; off <= N; off++) begin
         int cand;
         cand = int'(last) + off;
         if (cand >= N) cand = cand - N;
         if (!found && req[cand]) begin
            found = 1'b1;
            win   = IW'(cand);
         end
      end
   end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N  = 4,
   parameter int PW = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]    req,
   input  logic [N*PW-1:0] prio_flat,
   output logic            found,
   output logic [IW-1:0]   win
);
   logic [PW-1:0] pv [N];
   logic [PW-1:0] best;

   for (genvar g = 0; g < N; g++) begin : g_field
      assign pv[g] = prio_flat[g*PW +: PW];
   end

   always_comb begin
      found = 1'b0;
      win   = '0;
      best  = '0;
      for (int m = 0; m < N; m++) begin
         if (req[m] && (!found || pv[m] > best)) begin
            found = 1'b1;
            win   = IW'(m);
            best  = pv[m];
         end
      end
   end
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [SW-1:0] limit,
   output logic          hit
);
   localparam logic [SW-1:0] CNT_MAX = '1;
   logic [SW-1:0] cnt_q;

   assign hit = (limit != '0) && inc && (cnt_q == limit - SW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clr)                       cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)   cnt_q <= cnt_q + SW'(1);
   end

   // R6
   slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter #(
   parameter int N_MST  = 4,
   parameter int PRIO_W = 3,
   parameter int SLOT_W = 8,
   localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_MST-1:0]          req,
   input  logic                      xfer_active,
   input  logic                      xfer_single,
   input  logic                      burst_last,
   input  logic                      cfg_mode,
   input  logic [N_MST*PRIO_W-1:0]   cfg_prio,
   input  logic                      cfg_dflt_en,
   input  logic [IDX_W-1:0]          cfg_dflt_idx,
   input  logic [SLOT_W-1:0]         cfg_slot_limit,
   output logic [N_MST-1:0]          gnt,
   output logic [IDX_W-1:0]          gnt_idx,
   output logic                      gnt_vld
);
   import arb_pkg::*;

   if (N_MST < 2) begin : g_bad_n
      $error("bus_slot_arbiter: N_MST must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_pw
      $error("bus_slot_arbiter: PRIO_W must be at least 1");
   end
   if (SLOT_W < 1) begin : g_bad_sw
      $error("bus_slot_arbiter: SLOT_W must be at least 1");
   end

   logic             own_vld_q, own_vld_d;
   logic [IDX_W-1:0] own_idx_q, own_idx_d;
   logic             rr_found, pr_found, slot_hit, arb_pt, any_req;
   logic [IDX_W-1:0] rr_win, pr_win, pick;
   arb_mode_e        mode;

   assign mode    = arb_mode_e'(cfg_mode);
   assign any_req = |req;

   rr_pick #(.N(N_MST), .IW(IDX_W)) u_rr (
      .req(req), .last(own_idx_q), .found(rr_found), .win(rr_win));

   prio_pick #(.N(N_MST), .PW(PRIO_W), .IW(IDX_W)) u_prio (
      .req(req), .prio_flat(cfg_prio), .found(pr_found), .win(pr_win));

   slot_timer #(.SW(SLOT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(arb_pt),
      .inc(xfer_active & own_vld_q), .limit(cfg_slot_limit), .hit(slot_hit));

   assign pick   = (mode == ARB_PRIO) ? pr_win : rr_win;
   assign arb_pt = !own_vld_q || !xfer_active || xfer_single || burst_last || slot_hit;

   always_comb begin
      own_vld_d = own_vld_q;
      own_idx_d = own_idx_q;
      if (arb_pt) begin
         if (any_req) begin
            own_vld_d = 1'b1;
            own_idx_d = pick;
         end else if (cfg_dflt_en) begin
            own_vld_d = 1'b1;
            own_idx_d = cfg_dflt_idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vld_q <= 1'b0;
         own_idx_q <= IDX_W'(N_MST - 1);
      end else begin
         own_vld_q <= own_vld_d;
         own_idx_q <= own_idx_d;
      end
   end

   for (genvar g = 0; g < N_MST; g++) begin : g_gnt
      assign gnt[g] = own_vld_q && (own_idx_q == IDX_W'(g));
   end
   assign gnt_idx = own_idx_q;
   assign gnt_vld = own_vld_q;

   // R3
   hold_between_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_pt |=> $stable(gnt));

   // R10
   grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && any_req) |=> ((gnt & $past(req)) != '0));

   // R7
   park_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !any_req && cfg_dflt_en) |=> (gnt_vld && gnt_idx == $past(cfg_dflt_idx)));

   // R8
   park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !any_req && !cfg_dflt_en) |=> $stable(gnt));

   // R2
   onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
endmodule

// File: tb/bus_slot_arbiter_tb.sv
module bus_slot_arbiter_tb;
   localparam int N  = 4;
   localparam int PW = 3;
   localparam int SW = 8;
   localparam int IW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req = '0;
   logic            xfer_active = 1'b0, xfer_single = 1'b0, burst_last = 1'b0;
   logic            cfg_mode = 1'b0, cfg_dflt_en = 1'b0;
   logic [N*PW-1:0] cfg_prio = '0;
   logic [IW-1:0]   cfg_dflt_idx = '0;
   logic [SW-1:0]   cfg_slot_limit = '0;
   logic [N-1:0]    gnt;
   logic [IW-1:0]   gnt_idx;
   logic            gnt_vld;

   int n_chk = 0, n_err = 0;
   int m_vld, m_idx, m_cnt;
   bit finished = 0;

   bus_slot_arbiter #(.N_MST(N), .PRIO_W(PW), .SLOT_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .xfer_active(xfer_active),
      .xfer_single(xfer_single), .burst_last(burst_last), .cfg_mode(cfg_mode),
      .cfg_prio(cfg_prio), .cfg_dflt_en(cfg_dflt_en), .cfg_dflt_idx(cfg_dflt_idx),
      .cfg_slot_limit(cfg_slot_limit), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld));

   always #5 clk = ~clk;

   function automatic int rr_w(logic [N-1:0] r, int last);
      for (int off = 1; off <= N; off++) begin
         int c = (last + off) % N;
         if (r[c]) return c;
      end
      return -1;
   endfunction

   function automatic int pr_w(logic [N-1:0] r, logic [N*PW-1:0] p);
      int best = -1;
      for (int m = 0; m < N; m++)
         if (r[m] && (best < 0 || p[m*PW +: PW] > p[best*PW +: PW])) best = m;
      return best;
   endfunction

   task automatic check(string tag);
      logic [N-1:0] exp_g;
      exp_g = m_vld ? (N'(1) << m_idx) : '0;
      n_chk++;
      if (gnt !== exp_g || gnt_vld !== (m_vld != 0) || (m_vld && int'(gnt_idx) != m_idx)) begin
         n_err++;
         $display("FAIL %s: gnt=%b vld=%0b idx=%0d expected gnt=%b vld=%0d idx=%0d",
                  tag, gnt, gnt_vld, gnt_idx, exp_g, m_vld, m_idx);
      end
   endtask

   task automatic step(string tag);
      bit hit, arb;
      int nv, ni, nc;
      hit = (cfg_slot_limit != 0) && m_vld && xfer_active && (m_cnt == int'(cfg_slot_limit) - 1);
      arb = !m_vld || !xfer_active || xfer_single || burst_last || hit;
      nv = m_vld; ni = m_idx;
      if (arb) begin
         if (req != 0) begin
            nv = 1; ni = cfg_mode ? pr_w(req, cfg_prio) : rr_w(req, m_idx);
         end else if (cfg_dflt_en) begin
            nv = 1; ni = int'(cfg_dflt_idx);
         end
      end
      nc = arb ? 0 : ((m_cnt < 255) ? m_cnt + 1 : m_cnt);
      @(posedge clk);
      m_vld = nv; m_idx = ni; m_cnt = nc;
      @(negedge clk);
      check(tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      m_vld = 0; m_idx = N - 1; m_cnt = 0;
      repeat (3) @(negedge clk);
      check("R1");               // R1 reset state
      rst_n = 1'b1;
      step("R1");                // R1/R8: no request, no default -> still no owner
      step("R8");
      // R4 rotating order with single transfers
      req = 4'b1111; xfer_active = 1; xfer_single = 1;
      repeat (5) step("R4");
      req = 4'b0101;
      repeat (3) step("R4");
      // R8 park on last owner
      req = '0; xfer_active = 0; xfer_single = 0;
      repeat (2) step("R8");
      // R3 burst hold, switch only at burst_last
      req = 4'b1111; xfer_active = 1;
      repeat (4) step("R3");
      burst_last = 1; step("R3"); burst_last = 0;
      repeat (2) step("R3");
      // R6 slot limit breaks long bursts
      cfg_slot_limit = 8'd3;
      repeat (10) step("R6");
      cfg_slot_limit = 8'd1;
      repeat (3) step("R6");
      cfg_slot_limit = 8'd0;
      repeat (6) step("R6");
      // R5 priority mode
      cfg_mode = 1; xfer_single = 1;
      cfg_prio = {3'd2, 3'd5, 3'd5, 3'd1};   // m3=2 m2=5 m1=5 m0=1
      step("R5"); step("R5");
      req = 4'b1101; step("R5");
      req = 4'b1001; step("R5");
      req = 4'b0001; step("R5");
      // R7 default master parking, zero latency for it
      cfg_mode = 0; cfg_dflt_en = 1; cfg_dflt_idx = 2'd2;
      req = '0; xfer_active = 0; xfer_single = 0;
      step("R7");
      req = 4'b0100; check("R7");            // granted in the same cycle
      xfer_active = 1; xfer_single = 1; step("R7");
      req = '0; xfer_active = 0; xfer_single = 0; step("R7");
      req = 4'b0010; check("R7");            // non-default still waits
      step("R10");                           // granted one clock later
      // R9 default setting does not change contended order
      req = 4'b1111; xfer_active = 1; xfer_single = 1;
      repeat (5) step("R9");
      cfg_dflt_en = 0;
      repeat (3) step("R9");
      // random phase
      for (int cyc = 0; cyc < 4000; cyc++) begin
         if (cyc % 250 == 0) begin
            cfg_mode       = $urandom_range(0, 1);
            cfg_prio       = N*PW'($urandom);
            cfg_dflt_en    = $urandom_range(0, 1);
            cfg_dflt_idx   = IW'($urandom_range(0, N - 1));
            cfg_slot_limit = SW'($urandom_range(0, 6));
         end
         req         = N'($urandom) & N'($urandom);
         xfer_active = ($urandom_range(0, 9) < 8);
         xfer_single = ($urandom_range(0, 9) == 0);
         burst_last  = ($urandom_range(0, 15) == 0);
         step((cyc % 2) ? "R3" : "R2");
      end
      finish_run();
   end
endmodule